// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block drives the system reset of a chip. While the power-good input is low the reset output is held high. Once power-good rises, a hold counter keeps reset high for a time picked by a 2-bit hold code. After that a watchdog starts to count. Software must pulse the kick input before the period picked by a 2-bit watchdog code runs out. One watchdog code switches the watchdog off.

When the watchdog runs out, the block raises reset again for the selected hold time. In the same cycle it emits a one-cycle fail pulse that a status register elsewhere can capture. All times are parameters counted in clock ticks. The defaults are the nominal millisecond figures taken as tick counts, so a bench can use much smaller values. Both codes are sampled live, and the board or a register sets them. The usual settings are hold code 01 and watchdog code 11.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good_i` is low, `sys_rst_o` is 1 and `wd_fail_o` is 0, with no clock edge needed.
- R2: After `pwr_good_i` rises, `sys_rst_o` stays 1 for exactly H rising clock edges and is 0 after edge H. H is set by `hold_sel_i`: 00 gives HOLD_TICKS_0 (nominal 50 ms), 01 gives HOLD_TICKS_1 (200 ms), 10 gives HOLD_TICKS_2 (400 ms) and 11 gives HOLD_TICKS_3 (800 ms).
- R3: If `pwr_good_i` falls during a hold, reset stays asserted. The next rise of `pwr_good_i` starts a full H-edge hold from zero.
- R4: With `wd_sel_i` = 11, no timeout ever occurs. This also holds when code 11 is selected while a count is in progress.
- R5: The watchdog counts only while `sys_rst_o` is 0. With no kick, a timeout occurs on the T-th rising edge after the edge that released reset. T is set by `wd_sel_i`: 00 gives WD_TICKS_0 (nominal 1.4 s), 01 gives WD_TICKS_1 (200 ms) and 10 gives WD_TICKS_2 (25 ms).
- R6: A timeout sets `sys_rst_o` to 1 on the same edge. Reset then stays 1 for H edges, with H taken from `hold_sel_i` as in R2.
- R7: A timeout makes `wd_fail_o` 1 for exactly one cycle, starting on the edge that raises reset. Reset rises for no other reason while power is good.
- R8: A kick sampled high restarts the count from zero, so the next timeout comes T edges after the kick edge. A kick on the edge that would have expired wins, and no timeout occurs.
- R9: Any change of `wd_sel_i` restarts the count from zero, and the new period applies. A change on the expiry edge also prevents that timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_good_i | input | 1 | Supply valid; low acts as asynchronous reset of the block |
| kick_i | input | 1 | Watchdog restart strobe, sampled on rising edges |
| hold_sel_i | input | 2 | Reset hold time code |
| wd_sel_i | input | 2 | Watchdog period code; 11 disables the watchdog |
| sys_rst_o | output | 1 | System reset, active high |
| wd_fail_o | output | 1 | One-cycle watchdog timeout event |

## Verification
A restart and an expiry can fall on the same clock edge, because the counter sits at its last value exactly when a kick or a code change arrives. The bench counts edges from the reset release and applies the kick, or the change of watchdog code, so that it is sampled on precisely the edge of expiry. It then requires reset to stay low with no fail pulse on that edge. It also requires the next timeout to come one full period later, under the new code in the case of a code change.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_code_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/code_lookup.sv
module code_lookup #(
    parameter int unsigned W  = 8,
    parameter int unsigned V0 = 1,
    parameter int unsigned V1 = 1,
    parameter int unsigned V2 = 1,
    parameter int unsigned V3 = 1
) (
    input  logic [1:0]   code_i,
    output logic [W-1:0] ticks_o
);
    always_comb begin
        unique case (code_i)
            2'b00:   ticks_o = W'(V0);
            2'b01:   ticks_o = W'(V1);
            2'b10:   ticks_o = W'(V2);
            default: ticks_o = W'(V3);
        endcase
    end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned CW      = 10,
    parameter int unsigned MAX_LEN = 800
) (
    input  logic          clk_i,
    input  logic          pwr_good_i,
    input  logic [CW-1:0] ticks_i,
    input  logic          trip_i,
    output logic          rst_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } hold_st_t;

    localparam logic [CW:0] ONE = (CW+1)'(1);

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (({1'b0, st_q.cnt} + ONE) >= {1'b0, ticks_i}) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (trip_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            st_q <= '{busy: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o = st_q.busy;

    assert_hold_bounded_R2: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        st_q.cnt < CW'(MAX_LEN));

    assert_trip_asserts_R6: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (trip_i && !st_q.busy) |=> rst_o);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import sup_pkg::*;
#(
    parameter int unsigned CW      = 11,
    parameter int unsigned MAX_LEN = 1400
) (
    input  logic          clk_i,
    input  logic          pwr_good_i,
    input  logic          hold_i,
    input  logic          kick_i,
    input  logic [1:0]    code_i,
    input  logic [CW-1:0] ticks_i,
    output logic          expire_o,
    output logic          fail_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    code;
        logic          fail;
    } wd_st_t;

    localparam logic [CW:0] ONE = (CW+1)'(1);

    wd_st_t st_d, st_q;
    logic   restart, run, hit;

    always_comb begin
        restart = kick_i || (code_i != st_q.code);
        run     = !hold_i && (code_i != WD_OFF);
        hit     = run && !restart && (({1'b0, st_q.cnt} + ONE) >= {1'b0, ticks_i});

        st_d      = st_q;
        st_d.code = code_i;
        st_d.fail = hit;
        if (restart || !run || hit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            st_q <= '{cnt: '0, code: WD_OFF, fail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = hit;
    assign fail_o   = st_q.fail;

    assert_fail_single_R7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        fail_o |=> !fail_o);

    assert_off_quiet_R4: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (code_i == WD_OFF) |=> !fail_o);

    assert_kick_wins_R8: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        kick_i |=> !fail_o);

    assert_no_count_in_reset_R5: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        hold_i |=> (st_q.cnt == '0));

    assert_cnt_bounded_R5: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        st_q.cnt < CW'(MAX_LEN));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_TICKS_0 = 50,
    parameter int unsigned HOLD_TICKS_1 = 200,
    parameter int unsigned HOLD_TICKS_2 = 400,
    parameter int unsigned HOLD_TICKS_3 = 800,
    parameter int unsigned WD_TICKS_0   = 1400,
    parameter int unsigned WD_TICKS_1   = 200,
    parameter int unsigned WD_TICKS_2   = 25
) (
    input  logic       clk_i,
    input  logic       pwr_good_i,
    input  logic       kick_i,
    input  logic [1:0] hold_sel_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_rst_o,
    output logic       wd_fail_o
);
    localparam int unsigned HOLD_MAX = max_of4(HOLD_TICKS_0, HOLD_TICKS_1, HOLD_TICKS_2, HOLD_TICKS_3);
    localparam int unsigned WD_MAX   = max_of4(WD_TICKS_0, WD_TICKS_1, WD_TICKS_2, 1);
    localparam int unsigned ALL_MAX  = (HOLD_MAX > WD_MAX) ? HOLD_MAX : WD_MAX;
    localparam int unsigned CW       = $clog2(ALL_MAX + 1);

    logic [CW-1:0] hold_ticks;
    logic [CW-1:0] wd_ticks;
    logic          expire;

    code_lookup #(.W(CW), .V0(HOLD_TICKS_0), .V1(HOLD_TICKS_1),
                  .V2(HOLD_TICKS_2), .V3(HOLD_TICKS_3)) hold_lut_i (
        .code_i  (hold_sel_i),
        .ticks_o (hold_ticks)
    );

    code_lookup #(.W(CW), .V0(WD_TICKS_0), .V1(WD_TICKS_1),
                  .V2(WD_TICKS_2), .V3(1)) wd_lut_i (
        .code_i  (wd_sel_i),
        .ticks_o (wd_ticks)
    );

    hold_timer #(.CW(CW), .MAX_LEN(HOLD_MAX)) hold_i (
        .clk_i      (clk_i),
        .pwr_good_i (pwr_good_i),
        .ticks_i    (hold_ticks),
        .trip_i     (expire),
        .rst_o      (sys_rst_o)
    );

    wdog_timer #(.CW(CW), .MAX_LEN(WD_MAX)) wdog_i (
        .clk_i      (clk_i),
        .pwr_good_i (pwr_good_i),
        .hold_i     (sys_rst_o),
        .kick_i     (kick_i),
        .code_i     (wd_sel_i),
        .ticks_i    (wd_ticks),
        .expire_o   (expire),
        .fail_o     (wd_fail_o)
    );

    assert_fail_with_reset_R7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        wd_fail_o |-> sys_rst_o);

    assert_rise_has_cause_R7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $rose(sys_rst_o) |-> wd_fail_o);

endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H0 = 5, H1 = 7, H2 = 10, H3 = 13;
    localparam int W0 = 40, W1 = 18, W2 = 9;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       kick = 1'b0;
    logic [1:0] hold_sel = 2'b01;
    logic [1:0] wd_sel = 2'b11;
    logic       sys_rst;
    logic       wd_fail;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_supervisor #(
        .HOLD_TICKS_0(H0), .HOLD_TICKS_1(H1), .HOLD_TICKS_2(H2), .HOLD_TICKS_3(H3),
        .WD_TICKS_0(W0), .WD_TICKS_1(W1), .WD_TICKS_2(W2)
    ) dut_i (
        .clk_i(clk), .pwr_good_i(pwr_good), .kick_i(kick),
        .hold_sel_i(hold_sel), .wd_sel_i(wd_sel),
        .sys_rst_o(sys_rst), .wd_fail_o(wd_fail)
    );

    function automatic int hold_of(input logic [1:0] c);
        case (c)
            2'b00: return H0;
            2'b01: return H1;
            2'b10: return H2;
            default: return H3;
        endcase
    endfunction

    function automatic int wd_of(input logic [1:0] c);
        case (c)
            2'b00: return W0;
            2'b01: return W1;
            default: return W2;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic power_up(input logic [1:0] h, input logic [1:0] w);
        pwr_good = 1'b0;
        kick = 1'b0;
        hold_sel = h;
        wd_sel = w;
        tick(2);
        pwr_good = 1'b1;
        tick(hold_of(h) - 1);
        check(sys_rst == 1'b1, "R2 hold before last edge", int'(sys_rst), 1);
        tick(1);
        check(sys_rst == 1'b0, "R2 release after H edges", int'(sys_rst), 0);
    endtask

    task automatic t_reset_state();
        tick(1);
        #1;
        check(sys_rst == 1'b1, "R1 reset while power bad", int'(sys_rst), 1);
        check(wd_fail == 1'b0, "R1 no fail while power bad", int'(wd_fail), 0);
    endtask

    task automatic t_hold_codes();
        for (int c = 0; c < 4; c++) begin
            power_up(2'(c), 2'b11);
        end
    endtask

    task automatic t_power_glitch();
        hold_sel = 2'b10;
        wd_sel = 2'b11;
        pwr_good = 1'b0;
        tick(2);
        pwr_good = 1'b1;
        tick(H2 - 3);
        pwr_good = 1'b0;
        #1;
        check(sys_rst == 1'b1, "R3 reset on power drop", int'(sys_rst), 1);
        tick(1);
        pwr_good = 1'b1;
        tick(H2 - 1);
        check(sys_rst == 1'b1, "R3 full hold after restart", int'(sys_rst), 1);
        tick(1);
        check(sys_rst == 1'b0, "R3 release after restart", int'(sys_rst), 0);
    endtask

    task automatic t_disabled();
        int bad;
        power_up(2'b00, 2'b11);
        bad = 0;
        for (int i = 0; i < 3 * W0; i++) begin
            tick(1);
            if (wd_fail || sys_rst) bad++;
        end
        check(bad == 0, "R4 code 11 never times out", bad, 0);
        wd_sel = 2'b10;
        tick(W2 - 2);
        wd_sel = 2'b11;
        bad = 0;
        for (int i = 0; i < 3 * W2; i++) begin
            tick(1);
            if (wd_fail || sys_rst) bad++;
        end
        check(bad == 0, "R4 switch to 11 mid-count", bad, 0);
    endtask

    task automatic t_timeout(input logic [1:0] h, input logic [1:0] w);
        int t, hh;
        t = wd_of(w);
        hh = hold_of(h);
        power_up(h, w);
        tick(t - 1);
        check(wd_fail == 1'b0 && sys_rst == 1'b0, "R5 no timeout before T edges",
              int'({sys_rst, wd_fail}), 0);
        tick(1);
        check(wd_fail == 1'b1, "R7 fail pulse at timeout", int'(wd_fail), 1);
        check(sys_rst == 1'b1, "R6 reset raised at timeout", int'(sys_rst), 1);
        tick(1);
        check(wd_fail == 1'b0, "R7 fail lasts one cycle", int'(wd_fail), 0);
        tick(hh - 2);
        check(sys_rst == 1'b1, "R6 reset held for hold time", int'(sys_rst), 1);
        tick(1);
        check(sys_rst == 1'b0, "R6 reset released after hold", int'(sys_rst), 0);
    endtask

    task automatic t_kick_collision();
        power_up(2'b00, 2'b10);
        tick(W2 - 1);
        kick = 1'b1;
        tick(1);
        kick = 1'b0;
        check(wd_fail == 1'b0 && sys_rst == 1'b0, "R8 kick on expiry edge wins",
              int'({sys_rst, wd_fail}), 0);
        tick(W2 - 1);
        check(wd_fail == 1'b0, "R8 no timeout before T after kick", int'(wd_fail), 0);
        tick(1);
        check(wd_fail == 1'b1, "R8 timeout T edges after kick", int'(wd_fail), 1);
    endtask

    task automatic t_code_change();
        power_up(2'b00, 2'b10);
        tick(W2 - 1);
        wd_sel = 2'b01;
        tick(1);
        check(wd_fail == 1'b0 && sys_rst == 1'b0, "R9 code change on expiry edge",
              int'({sys_rst, wd_fail}), 0);
        tick(W1 - 1);
        check(wd_fail == 1'b0, "R9 no timeout before new period", int'(wd_fail), 0);
        tick(1);
        check(wd_fail == 1'b1, "R9 timeout at new period", int'(wd_fail), 1);
    endtask

    initial begin
        t_reset_state();
        t_hold_codes();
        t_power_glitch();
        t_disabled();
        t_timeout(2'b01, 2'b10);
        t_timeout(2'b11, 2'b01);
        t_timeout(2'b00, 2'b00);
        t_kick_collision();
        t_code_change();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule